// File: doc/BRIEF.md
# Level Interrupt Gateway and Claim/Complete Arbiter

This block is the interrupt collection point for a single target. It takes a vector of level-sensitive source lines, passes each through its own gateway, and keeps one pending flag per source. Every source has a 3-bit priority and an enable bit. An arbiter selects the highest-priority eligible pending source. The target line `irq_o` rises when that source's priority is strictly above the target's threshold.

The target services an interrupt in two steps. A one-cycle claim strobe takes the identifier shown on `claim_id_o`. At that same clock edge the selected source's pending flag clears and its gateway moves to the claimed state. While claimed, the gateway does not look at its source line. A later complete strobe carrying that identifier re-arms the gateway. If the line is still high at that moment, the gateway forwards a new request at once, so a level that stays high is serviced again rather than only once. A pending flag stays set even when the source line drops before the claim.

Source k, for k from 1 to NUM_SRC, is wired to `src_i[k-1]`, and its identifier is k. Identifier 0 means "no interrupt".

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset every gateway is ready with no pending flag, `claim_id_o` is 0 and `irq_o` is 0.
- R2: A source whose gateway is ready and whose line is high at a clock edge becomes pending at that edge.
- R3: A pending flag stays set when the source line deasserts. Only a claim of that source clears it.
- R4: `claim_id_o` shows the identifier of the pending source that is enabled and has the highest nonzero priority. Source k's priority is `prio_i[3k-1:3k-3]`. Ties go to the lowest identifier. A source with priority 0 or with its enable bit `en_i[k-1]` low is never shown.
- R5: A claim strobe clears the shown source's pending flag at that edge and moves its gateway to the claimed state. In the claimed state the source line has no effect, so that source is not shown again before its completion.
- R6: A complete strobe whose identifier is in the claimed state re-arms that gateway at the same edge. If the line is high then, the source is pending again right after that edge. If the line is low, the gateway becomes ready.
- R7: A complete strobe whose identifier is 0, out of range, or not in the claimed state changes nothing.
- R8: A claim strobe while `claim_id_o` is 0 changes no state.
- R9: `irq_o` is high exactly when the priority of the shown source is greater than `thresh_i`.
- R10: A claim of one source and a new assertion of another source at the same edge both take effect. The claimed source leaves the pending set and the newly asserting source enters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level source lines; bit k-1 is source k |
| prio_i | input | NUM_SRC*PRIO_W | Per-source priorities, source k at bits [PRIO_W*k-1 : PRIO_W*(k-1)] |
| en_i | input | NUM_SRC | Per-source enables |
| thresh_i | input | PRIO_W | Target threshold |
| claim_i | input | 1 | Claim strobe, one cycle |
| claim_id_o | output | ID_W | Identifier a claim would take now, 0 if none |
| complete_i | input | 1 | Complete strobe, one cycle |
| complete_id_i | input | ID_W | Identifier being completed |
| irq_o | output | 1 | Interrupt request to the target |

## Verification
Two events can land on the same edge. One is a claim of the shown source. The other is either a fresh assertion by a second source or a completion of a third source whose line is still high. The bench drives such collisions on purpose and also creates them by random traffic. At every cycle it compares `claim_id_o` and `irq_o` against a per-source gateway model. That model takes the claim first and then evaluates each other gateway against its own line, so a request lost in a collision appears as a mismatch on a later cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef enum logic [1:0] {
    GW_READY   = 2'd0,
    GW_PEND    = 2'd1,
    GW_CLAIMED = 2'd2
  } gw_state_e;
endpackage

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
  import irq_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_hit_i,
  input  logic complete_hit_i,
  output logic pend_o
);
  gw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GW_READY:   if (src_i) state_d = GW_PEND;
      GW_PEND:    if (claim_hit_i) state_d = GW_CLAIMED;
      GW_CLAIMED: if (complete_hit_i) state_d = src_i ? GW_PEND : GW_READY;
      default:    state_d = GW_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GW_READY;
    else         state_q <= state_d;
  end

  assign pend_o = (state_q == GW_PEND);

  p_pend_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_PEND && !claim_hit_i) |=> (state_q == GW_PEND));
  p_claim_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_CLAIMED && !complete_hit_i) |=> (state_q == GW_CLAIMED));
  p_rearm_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_CLAIMED && complete_hit_i && src_i) |=> (state_q == GW_PEND));
  p_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GW_READY && src_i) |=> (state_q == GW_PEND));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0]        elig_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]           best_id_o,
  output logic [PRIO_W-1:0]         best_prio_o
);
  // Scan from the top id down so an equal priority lets the lower id win.
  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i] && prio_i[i*PRIO_W +: PRIO_W] != '0 &&
          prio_i[i*PRIO_W +: PRIO_W] >= best_prio_o) begin
        best_prio_o = prio_i[i*PRIO_W +: PRIO_W];
        best_id_o   = ID_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [PRIO_W-1:0]         thresh_i,
  input  logic                      claim_i,
  output logic [ID_W-1:0]           claim_id_o,
  input  logic                      complete_i,
  input  logic [ID_W-1:0]           complete_id_i,
  output logic                      irq_o
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] elig;
  logic [PRIO_W-1:0]  best_prio;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gw
    localparam logic [ID_W-1:0] MyId = ID_W'(k + 1);
    logic claim_hit, complete_hit;
    assign claim_hit    = claim_i && (claim_id_o == MyId);
    assign complete_hit = complete_i && (complete_id_i == MyId);
    irq_gw_cell i_cell (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .src_i          (src_i[k]),
      .claim_hit_i    (claim_hit),
      .complete_hit_i (complete_hit),
      .pend_o         (pend[k])
    );
  end

  assign elig = pend & en_i;

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_arb (
    .elig_i      (elig),
    .prio_i      (prio_i),
    .best_id_o   (claim_id_o),
    .best_prio_o (best_prio)
  );

  assign irq_o = (best_prio > thresh_i);

  p_irq_has_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (claim_id_o != '0));
  p_empty_claim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o == '0 && !complete_i && src_i == '0) |=> $stable(pend));
  p_claim_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && claim_id_o != '0) |=> !pend[$past(claim_id_o) - 1'b1]);
  p_id_eligible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_id_o != '0) |-> elig[claim_id_o - 1'b1]);
endmodule

// File: tb/test_irq_gate_ctrl.sv
`timescale 1ns/1ps
module test_irq_gate_ctrl;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = $clog2(N + 1);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, en = '1;
  logic [N*PW-1:0] prio = '0;
  logic [PW-1:0] thr = '0;
  logic claim = 0, cmp = 0;
  logic [IW-1:0] cmp_id = '0;
  logic [IW-1:0] claim_id;
  logic irq;

  int n_chk = 0, n_bad = 0;
  int st [N];  // 0 ready, 1 pending, 2 claimed

  always #10 clk = ~clk;

  irq_gate_ctrl #(.NUM_SRC(N), .PRIO_W(PW)) i_irq_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .prio_i(prio), .en_i(en),
    .thresh_i(thr), .claim_i(claim), .claim_id_o(claim_id),
    .complete_i(cmp), .complete_id_i(cmp_id), .irq_o(irq));

  function automatic int exp_id();
    int b = 0, bp = 0;
    for (int i = 0; i < N; i++) begin
      int p = int'(prio[i*PW +: PW]);
      if (st[i] == 1 && en[i] && p > bp) begin bp = p; b = i + 1; end
    end
    return b;
  endfunction

  function automatic int exp_prio();
    int b = exp_id();
    return (b == 0) ? 0 : int'(prio[(b-1)*PW +: PW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Inputs are set at a negedge; compare, clock once, then update the model.
  task automatic step(string tag);
    int bid;
    #1;
    bid = exp_id();
    chk({tag, " id"}, int'(claim_id), bid);
    chk("R9 irq", int'(irq), (exp_prio() > int'(thr)) ? 1 : 0);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (st[i] == 1) begin
        if (claim && bid == i + 1) st[i] = 2;
      end else if (st[i] == 2) begin
        if (cmp && int'(cmp_id) == i + 1) st[i] = src[i] ? 1 : 0;
      end else if (src[i]) st[i] = 1;
    end
    @(negedge clk);
    claim = 0; cmp = 0;
  endtask

  task automatic set_prio(int id, int p);
    prio[(id-1)*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) st[i] = 0;
    for (int i = 1; i <= N; i++) set_prio(i, 1 + (i % 7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset id", int'(claim_id), 0);
    chk("R1 reset irq", int'(irq), 0);
    @(negedge clk);

    // R2 take, R3 hold after drop
    src[2] = 1; step("R2");
    src[2] = 0; step("R3");
    chk("R3 still shown", int'(claim_id), 3);
    // R5 claim, then held line blocked
    claim = 1; step("R5");
    src[2] = 1; step("R5"); step("R5");
    chk("R5 blocked", int'(claim_id), 0);
    // R7 bogus completes
    cmp = 1; cmp_id = 5; step("R7");
    cmp = 1; cmp_id = 0; step("R7");
    cmp = 1; cmp_id = IW'(15); step("R7");
    chk("R7 no effect", int'(claim_id), 0);
    // R8 empty claim
    claim = 1; step("R8");
    // R6 complete with level high re-pends
    cmp = 1; cmp_id = 3; step("R6");
    chk("R6 re-pend", int'(claim_id), 3);
    claim = 1; step("R6");
    src[2] = 0; cmp = 1; cmp_id = 3; step("R6");
    chk("R6 to ready", int'(claim_id), 0);
    // R10 claim + new assertion same edge
    src[4] = 1; step("R10");
    claim = 1; src[6] = 1; step("R10");
    chk("R10 new kept", int'(claim_id), 7);
    // R4 ties, zero priority, disabled
    set_prio(7, 4); set_prio(2, 4); set_prio(8, 0);
    src[1] = 1; src[7] = 1; en[0] = 0; src[0] = 1; step("R4");
    chk("R4 tie low id", int'(claim_id), 2);
    thr = 4; step("R9");
    chk("R9 at thr", int'(irq), 0);
    thr = 3; step("R9");
    src = '0;
    for (int i = 0; i < N; i++) begin claim = 1; step("R4"); end

    // constrained random
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) if ($urandom_range(0, 5) == 0) src[i] = ~src[i];
      claim = ($urandom_range(0, 2) == 0);
      cmp = ($urandom_range(0, 2) == 0);
      cmp_id = IW'($urandom_range(0, N + 1));
      if ($urandom_range(0, 63) == 0) begin
        for (int i = 1; i <= N; i++) set_prio(i, $urandom_range(0, 7));
        en = N'($urandom);
        thr = PW'($urandom_range(0, 7));
      end
      step((t % 2 == 0) ? "R4" : "R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule